// File: doc/BRIEF.md
# SECDED-Protected Register File with Error Event Reporting

This block is a 32-word by 32-bit general-purpose register file. Each word is held as a 39-bit single-error-correct, double-error-detect codeword. It has one synchronous write port and two independent combinational read ports. Every read decodes the stored codeword on its way out.

When a read hits a single flipped bit, the reader receives the corrected word. The stored copy is left as it is, so the same fault shows up again on every later read until the word is rewritten. When a read hits two flipped bits, the uncorrected data bits are still returned and the core goes on running. Each event is published on a registered two-bit severity code and a four-bit source code, which external monitoring logic can watch.

A write-side inject mask is XORed into the codeword as it is stored. This lets test logic plant single-bit and double-bit faults at exact bit positions.

Top module: `ecc_regfile`

## Requirements
- R1: A word written with a zero inject mask reads back unchanged on either port. The read causes status 2'b00 and source 4'b0000.
- R2: The two read ports are combinational and independent of each other. A write takes effect at the rising clock edge. A read of the address being written in that same cycle returns the old contents.
- R3: Register 0 reads as zero on both ports and ignores writes, whatever the data and inject mask. Reading it never raises an event.
- R4: A read whose codeword has exactly one flipped bit returns the originally written data. This holds for any of the 39 bit positions: a data bit, a check bit or the overall parity bit. The read reports status 2'b10 and source 4'b0001.
- R5: A correction is never written back. Re-reading a word that holds a single-bit fault reports 2'b10 again and again returns corrected data.
- R6: A read whose syndrome is nonzero with even overall parity reports status 2'b11 and source 4'b0001. The same applies when the parity is odd but the syndrome points past bit 38. In both cases the data bits of the stored codeword are returned uncorrected.
- R7: Status and source are registered. After a rising edge they describe the reads presented during the cycle before that edge. They return to zero after an edge at which neither port saw an event.
- R8: When both ports raise events in the same cycle, the more severe status is reported: 2'b11 over 2'b10 over 2'b00.
- R9: Status is never 2'b01. Source is only ever 4'b0000 or 4'b0001, and it is 4'b0001 exactly when status is nonzero.
- R10: Asynchronous reset (rst_ni low) clears every word to the all-zero codeword, which is a valid encoding of zero. It also clears status and source to zero.
- R11: Codeword layout:
  - Bit 0 is overall even parity over all 39 bits.
  - Bits 1, 2, 4, 8, 16 and 32 are Hamming check bits. Each covers the positions whose index has that bit set.
  - Data bits 0 to 31 fill the remaining positions 3, 5, 6, 7, 9 and onward, in ascending order, so data bit 31 sits at bit 38.
  - Bit i of the inject mask flips codeword bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Write address |
| wdata_i | input | 32 | Write data |
| winj_i | input | 39 | Bit flip mask XORed into the stored codeword |
| raddr_a_i | input | 5 | Read port A address |
| rdata_a_o | output | 32 | Read port A data (corrected when possible) |
| raddr_b_i | input | 5 | Read port B address |
| rdata_b_o | output | 32 | Read port B data (corrected when possible) |
| ecc_status_o | output | 2 | Registered event severity: 00 none, 10 corrected, 11 uncorrectable |
| ecc_source_o | output | 4 | Registered event source: 0000 none, 0001 register file |

## Verification
Faults cannot arise from ordinary writes, so the hardest states to reach from the ports are a stored single-bit fault and a stored double-bit fault. This is especially true of faults in check bits and in the overall parity bit, and of a double fault in which one of the two flips is the parity bit. The stimulus uses the inject mask to plant each case at a chosen codeword position, derived from the layout in R11. It then reads the word back and compares the returned data and the status code one edge later against values worked out from that layout. A second hard case is two ports reporting different severities in the same cycle. It is reached by pointing port A and port B at differently faulted words at once, in both port orders.

// File: rtl/ecc_rf_pkg.sv
package ecc_rf_pkg;

  typedef enum logic [1:0] {
    ST_NONE   = 2'b00,
    ST_RSVD   = 2'b01,
    ST_CORR   = 2'b10,
    ST_UNCORR = 2'b11
  } ecc_st_e;

  localparam logic [3:0] SRC_NONE = 4'b0000;
  localparam logic [3:0] SRC_GPR  = 4'b0001;

  // Hamming check bits needed to cover dw data bits
  function automatic int chk_bits(int dw);
    int p;
    p = 0;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  // Codeword position of data bit i (non-power-of-two slots from 3 upward)
  function automatic int data_pos(int i);
    int n;
    n = 0;
    for (int p = 3; p < 1024; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == i) return p;
        n++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/ecc_rf_enc.sv
module ecc_rf_enc
  import ecc_rf_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int CHK_W  = 6,
  localparam int NPOS   = DATA_W + CHK_W,
  localparam int CW_W   = NPOS + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);

  logic [CW_W-1:0] cw;
  logic            par;

  always_comb begin
    cw  = '0;
    par = 1'b0;
    for (int i = 0; i < DATA_W; i++) cw[data_pos(i)] = data_i[i];
    for (int k = 0; k < CHK_W; k++) begin
      par = 1'b0;
      for (int p = 1; p <= NPOS; p++) begin
        if (((p >> k) & 1) != 0) par = par ^ cw[p];
      end
      cw[1 << k] = par;
    end
    cw[0] = ^cw[NPOS:1];
  end

  assign cw_o = cw;

endmodule

// File: rtl/ecc_rf_dec.sv
module ecc_rf_dec
  import ecc_rf_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int CHK_W  = 6,
  localparam int NPOS   = DATA_W + CHK_W,
  localparam int CW_W   = NPOS + 1
) (
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output ecc_st_e           st_o
);

  logic [CHK_W-1:0] syn;
  logic             odd;
  logic [CW_W-1:0]  fixed;

  always_comb begin
    syn = '0;
    for (int k = 0; k < CHK_W; k++) begin
      for (int p = 1; p <= NPOS; p++) begin
        if (((p >> k) & 1) != 0) syn[k] = syn[k] ^ cw_i[p];
      end
    end
    odd   = ^cw_i;
    fixed = cw_i;
    st_o  = ST_NONE;
    if (odd) begin
      if (syn == '0) begin
        st_o = ST_CORR;                  // parity bit itself flipped
      end else if (int'(syn) <= NPOS) begin
        fixed[syn] = ~fixed[syn];
        st_o       = ST_CORR;
      end else begin
        st_o = ST_UNCORR;                // syndrome outside the word
      end
    end else if (syn != '0) begin
      st_o = ST_UNCORR;
    end
    for (int i = 0; i < DATA_W; i++) data_o[i] = fixed[data_pos(i)];
  end

endmodule

// File: rtl/ecc_rf_evt.sv
module ecc_rf_evt
  import ecc_rf_pkg::*;
#(
  parameter int         NPORT  = 2,
  parameter logic [3:0] SRC_ID = SRC_GPR
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ecc_st_e    st_i [NPORT],
  output logic [1:0] status_o,
  output logic [3:0] source_o
);

  ecc_st_e    worst;
  logic [1:0] status_q;
  logic [3:0] source_q;

  // Encoding order equals severity order
  always_comb begin
    worst = ST_NONE;
    for (int n = 0; n < NPORT; n++) begin
      if (st_i[n] > worst) worst = st_i[n];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= ST_NONE;
      source_q <= SRC_NONE;
    end else begin
      status_q <= worst;
      source_q <= (worst != ST_NONE) ? SRC_ID : SRC_NONE;
    end
  end

  assign status_o = status_q;
  assign source_o = source_q;

endmodule

// File: rtl/ecc_regfile.sv
module ecc_regfile
  import ecc_rf_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int ADDR_W = 5,
  localparam int CHK_W  = chk_bits(DATA_W),
  localparam int CW_W   = DATA_W + CHK_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CW_W-1:0]   winj_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic [1:0]        ecc_status_o,
  output logic [3:0]        ecc_source_o
);

  localparam int NREG  = 1 << ADDR_W;
  localparam int NPORT = 2;

  logic [CW_W-1:0]   mem_q [NREG];
  logic [CW_W-1:0]   wr_cw;
  logic [ADDR_W-1:0] raddr [NPORT];
  logic [DATA_W-1:0] rdata [NPORT];
  ecc_st_e           rd_st [NPORT];

  ecc_rf_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
    .data_i (wdata_i),
    .cw_o   (wr_cw)
  );

  // All-zero codeword is a valid encoding of zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) mem_q[r] <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      mem_q[waddr_i] <= wr_cw ^ winj_i;
    end
  end

  assign raddr[0]  = raddr_a_i;
  assign raddr[1]  = raddr_b_i;
  assign rdata_a_o = rdata[0];
  assign rdata_b_o = rdata[1];

  for (genvar g = 0; g < NPORT; g++) begin : g_rd
    logic [CW_W-1:0] cw_sel;
    assign cw_sel = (raddr[g] == '0) ? '0 : mem_q[raddr[g]];
    ecc_rf_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
      .cw_i   (cw_sel),
      .data_o (rdata[g]),
      .st_o   (rd_st[g])
    );
  end

  ecc_rf_evt #(.NPORT(NPORT), .SRC_ID(SRC_GPR)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .st_i     (rd_st),
    .status_o (ecc_status_o),
    .source_o (ecc_source_o)
  );

endmodule

// File: rtl/ecc_regfile_chk.sv
module ecc_regfile_chk #(
  parameter  int DATA_W = 32,
  parameter  int ADDR_W = 5,
  parameter  int CW_W   = 39
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [CW_W-1:0]   winj_i,
  input logic [ADDR_W-1:0] raddr_a_i,
  input logic [DATA_W-1:0] rdata_a_o,
  input logic [ADDR_W-1:0] raddr_b_i,
  input logic [DATA_W-1:0] rdata_b_o,
  input logic [1:0]        ecc_status_o,
  input logic [3:0]        ecc_source_o
);

  AST_CLEAN_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0 && winj_i == '0) |=>
      (raddr_a_i != $past(waddr_i) || rdata_a_o == $past(wdata_i))); // R1

  AST_X0_ZERO_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == '0) |-> (rdata_a_o == '0)); // R3

  AST_X0_ZERO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_b_i == '0) |-> (rdata_b_o == '0)); // R3

  AST_X0_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == '0 && raddr_b_i == '0) |=> (ecc_status_o == 2'b00)); // R3

  AST_NO_RSVD_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_status_o != 2'b01); // R9

  AST_SOURCE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_source_o == ((ecc_status_o != 2'b00) ? 4'b0001 : 4'b0000)); // R9

endmodule

bind ecc_regfile ecc_regfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CW_W(CW_W)) chk_i (.*);

// File: tb/ecc_regfile_tb_top.sv
module ecc_regfile_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  waddr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [38:0] winj_i = '0;
  logic [4:0]  raddr_a_i = '0;
  logic [31:0] rdata_a_o;
  logic [4:0]  raddr_b_i = '0;
  logic [31:0] rdata_b_o;
  logic [1:0]  ecc_status_o;
  logic [3:0]  ecc_source_o;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  ecc_regfile dut_i (.*);

  typedef struct packed {
    logic [4:0]  addr;
    logic [31:0] data;
    logic [38:0] inj;
    logic [31:0] exp;
    logic [1:0]  st;
  } vec_t;

  // Mask positions per R11: bit0 parity, 1/2/4/8/16/32 check, 3->d0, 5->d1, 38->d31
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{5'd1,  32'hA5A5_0F0F, 39'h0,                 32'hA5A5_0F0F, 2'b00},
    '{5'd2,  32'hFFFF_FFFF, 39'h0,                 32'hFFFF_FFFF, 2'b00},
    '{5'd3,  32'h1234_5678, 39'h1 << 3,            32'h1234_5678, 2'b10},
    '{5'd4,  32'hDEAD_BEEF, 39'h1 << 38,           32'hDEAD_BEEF, 2'b10},
    '{5'd5,  32'h0000_0000, 39'h1 << 32,           32'h0000_0000, 2'b10},
    '{5'd6,  32'hCAFE_F00D, 39'h1,                 32'hCAFE_F00D, 2'b10},
    '{5'd7,  32'h8765_4321, 39'h6,                 32'h8765_4321, 2'b11},
    '{5'd8,  32'h1111_1111, 39'h28,                32'h1111_1112, 2'b11},
    '{5'd31, 32'h0F0F_F0F0, 39'h0,                 32'h0F0F_F0F0, 2'b00},
    '{5'd9,  32'h0000_0000, 39'h9,                 32'h0000_0001, 2'b11}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [38:0] m);
    @(negedge clk_i);
    we_i = 1'b1; waddr_i = a; wdata_i = d; winj_i = m;
    @(negedge clk_i);
    we_i = 1'b0; winj_i = '0;
  endtask

  // Present addresses, check data now, check status after the next edge
  task automatic rd(input string tag, input logic [4:0] a, input logic [4:0] b,
                    input logic [31:0] ea, input logic [31:0] eb, input logic [1:0] es);
    raddr_a_i = a; raddr_b_i = b;
    #1;
    chk({tag, " data_a"}, rdata_a_o, ea);
    chk({tag, " data_b"}, rdata_b_o, eb);
    @(negedge clk_i);
    chk({tag, " status"}, {30'd0, ecc_status_o}, {30'd0, es});
    chk({tag, " source R9"}, {28'd0, ecc_source_o}, (es != 2'b00) ? 32'd1 : 32'd0);
  endtask

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    raddr_a_i = 5'd5; raddr_b_i = 5'd31;
    #2;
    // R10: reset state
    chk("R10 status in reset", {30'd0, ecc_status_o}, 32'd0);
    chk("R10 source in reset", {28'd0, ecc_source_o}, 32'd0);
    chk("R10 data_a in reset", rdata_a_o, 32'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    rd("R10 post-reset", 5'd5, 5'd31, 32'd0, 32'd0, 2'b00);

    // Vector table: R1 clean, R4 single, R6/R11 double
    for (int v = 0; v < NVEC; v++) begin
      wr(VECS[v].addr, VECS[v].data, VECS[v].inj);
      rd((VECS[v].st == 2'b00) ? "R1" : (VECS[v].st == 2'b10) ? "R4/R11" : "R6/R11",
         VECS[v].addr, 5'd0, VECS[v].exp, 32'd0, VECS[v].st);
    end

    // R3: x0 ignores writes, even with injected faults
    wr(5'd0, 32'hFFFF_FFFF, 39'h1 << 3);
    rd("R3 x0", 5'd0, 5'd0, 32'd0, 32'd0, 2'b00);

    // R5 and R7: re-read faulty word after a clean one
    rd("R7 clean between", 5'd1, 5'd0, 32'hA5A5_0F0F, 32'd0, 2'b00);
    rd("R5 reread", 5'd3, 5'd0, 32'h1234_5678, 32'd0, 2'b10);
    rd("R5 reread again", 5'd3, 5'd0, 32'h1234_5678, 32'd0, 2'b10);

    // R7: status lags the read by one edge
    rd("R7 idle", 5'd1, 5'd0, 32'hA5A5_0F0F, 32'd0, 2'b00);
    raddr_a_i = 5'd7;
    #1;
    chk("R7 not yet", {30'd0, ecc_status_o}, 32'd0);
    @(negedge clk_i);
    chk("R7 after edge", {30'd0, ecc_status_o}, 32'd3);
    rd("R7 back to zero", 5'd1, 5'd0, 32'hA5A5_0F0F, 32'd0, 2'b00);

    // R8: severity merge across ports
    rd("R8 a corr b uncorr", 5'd3, 5'd7, 32'h1234_5678, 32'h8765_4321, 2'b11);
    rd("R8 a uncorr b corr", 5'd7, 5'd3, 32'h8765_4321, 32'h1234_5678, 2'b11);
    rd("R8 a corr b clean", 5'd3, 5'd2, 32'h1234_5678, 32'hFFFF_FFFF, 2'b10);
    rd("R8 b corr only", 5'd2, 5'd4, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 2'b10);

    // R2: write and read of same address in one cycle
    raddr_a_i = 5'd2; raddr_b_i = 5'd1;
    @(negedge clk_i);
    we_i = 1'b1; waddr_i = 5'd1; wdata_i = 32'h0000_0055; winj_i = '0;
    #1;
    chk("R2 old value same cycle", rdata_b_o, 32'hA5A5_0F0F);
    chk("R2 other port independent", rdata_a_o, 32'hFFFF_FFFF);
    @(negedge clk_i);
    we_i = 1'b0;
    #1;
    chk("R2 new value after edge", rdata_b_o, 32'h0000_0055);

    @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule